// File: doc/BRIEF.md
# Ring Shared-Memory Node Interface

This block connects one processor node to a unidirectional slotted ring on which every node's memory forms one shared address space. The node keeps a small table of cached blocks, and each table entry holds its own one-word data slot. CPU reads and writes are served locally when the table allows it. Otherwise the node waits for the circulating token, puts a coherence packet on the ring in place of the token, and completes the CPU request when its own packet comes back. Each passing packet from another node is snooped. The node either answers it from its cache, drops its own copy, or accepts an evicted block back as its home. It then forwards the packet with one cycle of latency.

A ring slot carries a valid bit, a 3-bit kind, a source node number, a filled (inhibit) flag, a block address and one data word. Kinds are encoded as 1 token, 2 read, 3 invalidate, 4 read-and-invalidate, 5 evict. Block address `a` is homed at node `a >> HOME_W`. Each node permanently reserves `2**HOME_W` table entries for its own home blocks. Those entries are never chosen as eviction victims.

Top module: `ring_dsm_node`

## Requirements
- R1: After reset, ring outputs are empty (valid 0, all fields 0) and the CPU acknowledge is low. The home blocks `NODE_ID*2**HOME_W + i` are held valid and exclusive, and each holds data 0.
- R2: A CPU read of a valid held block raises `cpu_ack_o` for exactly the cycle after the request is sampled, returns the held data, and puts nothing on the ring.
- R3: A CPU write to a held block that is exclusive completes in the same way, with no ring traffic. A later read returns the written data.
- R4: A packet from another node that touches no block held here is forwarded with every field unchanged one cycle later. A token is forwarded unchanged when the node has nothing to send, and so is an empty slot.
- R5: A read miss waits for a token, replaces it with a read packet (kind 2, src NODE_ID, filled 0, data 0). When that packet returns, the node stores the packet data as a shared copy, acknowledges with that data, and in the same slot emits a token (kind 1, src NODE_ID, filled 0, address 0, data 0).
- R6: A foreign read packet with filled 0 that hits a valid held block leaves with filled 1 and the held data, and the local copy loses exclusivity. A foreign packet whose filled flag is already set is not answered.
- R7: A write to a held block that is not exclusive first sends an invalidate packet (kind 3). When the packet returns, the write is performed, the block becomes exclusive and the CPU is acknowledged.
- R8: A write miss sends a read-and-invalidate packet (kind 4). On return the carried data is stored, the write data overwrites it, and the block is held exclusive.
- R9: A foreign invalidate or read-and-invalidate that hits a held block discards the local copy, so a later local read goes to the ring. A read-and-invalidate with filled 0 is first answered with the held data and filled 1.
- R10: A miss with no free entry evicts a valid, non-home entry chosen pseudo-randomly. An evict packet (kind 5) carries the victim's address and data, and after it returns the original request proceeds. Home blocks are never sent out.
- R11: A foreign evict packet with filled 0 for a block homed here is stored into its home entry as a valid, non-exclusive copy, and it leaves with filled 1.
- R12: If the block targeted by a pending invalidate is discarded by another node's packet before the invalidate returns, the write is not acknowledged on that return and is retried as a write miss.
- R13: The acknowledge is a one-cycle pulse, and it is low in the cycle after any acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU request, held until acknowledged |
| cpu_we_i | input | 1 | 1 write, 0 read |
| cpu_addr_i | input | ADDR_W | Block address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ack_o | output | 1 | Request complete, one-cycle pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with acknowledge |
| ring_vld_i | input | 1 | Incoming slot holds a packet |
| ring_kind_i | input | 3 | Incoming packet kind |
| ring_src_i | input | NODE_W | Incoming packet source node |
| ring_inh_i | input | 1 | Incoming filled flag |
| ring_addr_i | input | ADDR_W | Incoming block address |
| ring_data_i | input | DATA_W | Incoming data word |
| ring_vld_o | output | 1 | Outgoing slot holds a packet |
| ring_kind_o | output | 3 | Outgoing packet kind |
| ring_src_o | output | NODE_W | Outgoing packet source node |
| ring_inh_o | output | 1 | Outgoing filled flag |
| ring_addr_o | output | ADDR_W | Outgoing block address |
| ring_data_o | output | DATA_W | Outgoing data word |

## Verification
The bench builds the node as node 1 of four, with four table entries of which two are home entries, 4-bit addresses and 16-bit data. That leaves exactly two cacheable entries. Two remote fills therefore exhaust the free space, and the eviction path is reached, with the pseudo-random victim constrained to a set of two known blocks. The bench itself stands in for the rest of the ring. This lets it inject foreign snoops between token capture and packet return, which makes the lost-exclusivity retry directly reachable.

// File: rtl/ring_dsm_pkg.sv
package ring_dsm_pkg;
  typedef enum logic [2:0] {
    PK_NONE  = 3'd0,
    PK_TOKEN = 3'd1,
    PK_READ  = 3'd2,
    PK_INVAL = 3'd3,
    PK_RDINV = 3'd4,
    PK_EVICT = 3'd5
  } pkt_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TOK,
    ST_FLY,
    ST_DONE
  } node_st_e;
endpackage

// File: rtl/rdn_lookup.sv
module rdn_lookup #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             vld_i,
  input  logic [ENTRIES-1:0]             home_i,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_i,
  input  logic [ADDR_W-1:0]              addr_i,
  output logic                           match_o,
  output logic [IDX_W-1:0]               idx_o
);
  // home entries keep their tag while invalid, so they still match
  always_comb begin
    match_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!match_o && (vld_i[i] || home_i[i]) && tag_i[i] == addr_i) begin
        match_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rdn_slot_pick.sv
module rdn_slot_pick #(
  parameter int ENTRIES = 4,
  parameter int LFSR_W  = 8,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED = 8'h01,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] vld_i,
  input  logic [ENTRIES-1:0] home_i,
  output logic               free_ok_o,
  output logic [IDX_W-1:0]   free_idx_o,
  output logic               vic_ok_o,
  output logic [IDX_W-1:0]   vic_idx_o
);
  logic [LFSR_W-1:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & TAPS)};
  end

  always_comb begin
    free_ok_o  = 1'b0;
    free_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_ok_o && !vld_i[i] && !home_i[i]) begin
        free_ok_o  = 1'b1;
        free_idx_o = IDX_W'(i);
      end
    end
  end

  // ineligible candidate: wait for the next LFSR step
  assign vic_idx_o = lfsr_q[IDX_W-1:0];
  assign vic_ok_o  = vld_i[vic_idx_o] && !home_i[vic_idx_o];

  AST_LFSR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R10
endmodule

// File: rtl/ring_dsm_node.sv
module ring_dsm_node
  import ring_dsm_pkg::*;
#(
  parameter int NODE_ID = 1,
  parameter int NODE_W  = 2,
  parameter int ENTRIES = 4,
  parameter int HOME_W  = 1,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int LFSR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              ring_vld_i,
  input  logic [2:0]        ring_kind_i,
  input  logic [NODE_W-1:0] ring_src_i,
  input  logic              ring_inh_i,
  input  logic [ADDR_W-1:0] ring_addr_i,
  input  logic [DATA_W-1:0] ring_data_i,
  output logic              ring_vld_o,
  output logic [2:0]        ring_kind_o,
  output logic [NODE_W-1:0] ring_src_o,
  output logic              ring_inh_o,
  output logic [ADDR_W-1:0] ring_addr_o,
  output logic [DATA_W-1:0] ring_data_o
);
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int HOME_CNT = 1 << HOME_W;
  localparam logic [NODE_W-1:0] SELF = NODE_W'(NODE_ID);

  typedef struct packed {
    logic              vld;
    pkt_kind_e         kind;
    logic [NODE_W-1:0] src;
    logic              inh;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pkt_t;

  function automatic pkt_t mk_pkt(pkt_kind_e k, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    mk_pkt = '{vld: 1'b1, kind: k, src: SELF, inh: 1'b0, addr: a, data: d};
  endfunction

  logic [ENTRIES-1:0]             tbl_vld, tbl_excl, tbl_home;
  logic [ENTRIES-1:0][ADDR_W-1:0] tbl_tag;
  logic [ENTRIES-1:0][DATA_W-1:0] tbl_data;

  node_st_e          st_q;
  pkt_t              pend_q, rout_q, rout_d, rin;
  logic [IDX_W-1:0]  tgt_q;
  logic [DATA_W-1:0] rdata_q;

  logic             r_match, c_match, free_ok, vic_ok;
  logic [IDX_W-1:0] r_idx, c_idx, free_idx, vic_idx;

  assign rin = '{vld: ring_vld_i, kind: pkt_kind_e'(ring_kind_i), src: ring_src_i,
                 inh: ring_inh_i, addr: ring_addr_i, data: ring_data_i};

  rdn_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_ring_lu (
    .vld_i(tbl_vld), .home_i(tbl_home), .tag_i(tbl_tag), .addr_i(rin.addr),
    .match_o(r_match), .idx_o(r_idx));

  rdn_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cpu_lu (
    .vld_i(tbl_vld), .home_i(tbl_home), .tag_i(tbl_tag), .addr_i(cpu_addr_i),
    .match_o(c_match), .idx_o(c_idx));

  rdn_slot_pick #(.ENTRIES(ENTRIES), .LFSR_W(LFSR_W)) u_pick (
    .clk_i, .rst_ni, .vld_i(tbl_vld), .home_i(tbl_home),
    .free_ok_o(free_ok), .free_idx_o(free_idx), .vic_ok_o(vic_ok), .vic_idx_o(vic_idx));

  // packet classification
  logic is_tok, own_ret, foreign, r_hit, fill, drop, ev_take, snoop_act, c_hit;
  assign is_tok  = rin.vld && rin.kind == PK_TOKEN;
  assign own_ret = rin.vld && rin.src == SELF &&
                   rin.kind inside {PK_READ, PK_INVAL, PK_RDINV, PK_EVICT};
  assign foreign = rin.vld && rin.src != SELF &&
                   rin.kind inside {PK_READ, PK_INVAL, PK_RDINV, PK_EVICT};
  assign r_hit   = r_match && tbl_vld[r_idx];
  assign fill    = foreign && r_hit && !rin.inh && rin.kind inside {PK_READ, PK_RDINV};
  assign drop    = foreign && r_hit && rin.kind inside {PK_INVAL, PK_RDINV};
  assign ev_take = foreign && rin.kind == PK_EVICT && !rin.inh && r_match && tbl_home[r_idx];
  assign snoop_act = fill || drop || ev_take;
  assign c_hit   = c_match && tbl_vld[c_idx];

  always_comb begin
    rout_d = rin;
    if (own_ret) begin
      rout_d = mk_pkt(PK_TOKEN, '0, '0);
    end else if (is_tok && st_q == ST_TOK) begin
      rout_d = pend_q;
    end else if (fill) begin
      rout_d.inh  = 1'b1;
      rout_d.data = tbl_data[r_idx];
    end else if (ev_take) begin
      rout_d.inh = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pend_q  <= '0;
      rout_q  <= '0;
      tgt_q   <= '0;
      rdata_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tbl_vld[i]  <= (i < HOME_CNT);
        tbl_excl[i] <= (i < HOME_CNT);
        tbl_home[i] <= (i < HOME_CNT);
        tbl_tag[i]  <= ADDR_W'((NODE_ID << HOME_W) + i);
        tbl_data[i] <= '0;
      end
    end else begin
      rout_q <= rout_d;
      // snoop side; never collides with the CPU side below
      if (fill) tbl_excl[r_idx] <= 1'b0;
      if (drop) begin
        tbl_vld[r_idx]  <= 1'b0;
        tbl_excl[r_idx] <= 1'b0;
      end
      if (ev_take) begin
        tbl_vld[r_idx]  <= 1'b1;
        tbl_excl[r_idx] <= 1'b0;
        tbl_data[r_idx] <= rin.data;
      end

      unique case (st_q)
        ST_IDLE: if (cpu_req_i && !snoop_act) begin
          if (c_hit && !cpu_we_i) begin
            rdata_q <= tbl_data[c_idx];
            st_q    <= ST_DONE;
          end else if (c_hit && tbl_excl[c_idx]) begin
            tbl_data[c_idx] <= cpu_wdata_i;
            st_q            <= ST_DONE;
          end else if (c_hit) begin
            pend_q <= mk_pkt(PK_INVAL, cpu_addr_i, '0);
            tgt_q  <= c_idx;
            st_q   <= ST_TOK;
          end else if (c_match || free_ok) begin
            pend_q <= mk_pkt(cpu_we_i ? PK_RDINV : PK_READ, cpu_addr_i, '0);
            tgt_q  <= c_match ? c_idx : free_idx;
            st_q   <= ST_TOK;
          end else if (vic_ok) begin
            pend_q            <= mk_pkt(PK_EVICT, tbl_tag[vic_idx], tbl_data[vic_idx]);
            tbl_vld[vic_idx]  <= 1'b0;
            tbl_excl[vic_idx] <= 1'b0;
            tgt_q             <= vic_idx;
            st_q              <= ST_TOK;
          end
        end
        ST_TOK: if (is_tok) st_q <= ST_FLY;
        ST_FLY: if (own_ret) begin
          unique case (pend_q.kind)
            PK_READ: begin
              tbl_tag[tgt_q]  <= pend_q.addr;
              tbl_data[tgt_q] <= rin.data;
              tbl_vld[tgt_q]  <= 1'b1;
              tbl_excl[tgt_q] <= 1'b0;
              rdata_q         <= rin.data;
              st_q            <= ST_DONE;
            end
            PK_RDINV: begin
              tbl_tag[tgt_q]  <= pend_q.addr;
              tbl_data[tgt_q] <= cpu_wdata_i;
              tbl_vld[tgt_q]  <= 1'b1;
              tbl_excl[tgt_q] <= 1'b1;
              st_q            <= ST_DONE;
            end
            PK_INVAL: begin
              if (tbl_vld[tgt_q]) begin
                tbl_excl[tgt_q] <= 1'b1;
                tbl_data[tgt_q] <= cpu_wdata_i;
                st_q            <= ST_DONE;
              end else begin
                st_q <= ST_IDLE;  // copy lost in flight: retry as miss
              end
            end
            default: st_q <= ST_IDLE;
          endcase
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ack_o   = (st_q == ST_DONE);
  assign cpu_rdata_o = rdata_q;
  assign ring_vld_o  = rout_q.vld;
  assign ring_kind_o = rout_q.kind;
  assign ring_src_o  = rout_q.src;
  assign ring_inh_o  = rout_q.inh;
  assign ring_addr_o = rout_q.addr;
  assign ring_data_o = rout_q.data;

  AST_FWD_UNCHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    foreign && !snoop_act |=> rout_q == $past(rin)); // R4
  AST_TOKEN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_ret |=> ring_vld_o && ring_kind_o == PK_TOKEN); // R5
  AST_FILLED_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    foreign && rin.inh |=> ring_inh_o && ring_data_o == $past(rin.data)); // R6
  AST_EVICT_NOT_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_vld_o && ring_kind_o == PK_EVICT && ring_src_o == SELF
    |-> (ring_addr_o >> HOME_W) != ADDR_W'(NODE_ID)); // R10
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o); // R13

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    AST_EXCL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tbl_excl[g] |-> tbl_vld[g]); // R7
  end
endmodule

// File: tb/ring_dsm_node_tb_top.sv
`timescale 1ns/1ps
module ring_dsm_node_tb_top;
  localparam int K_TOK = 1, K_RD = 2, K_INV = 3, K_RDI = 4, K_EVC = 5;

  typedef struct packed {
    logic        vld;
    logic [2:0]  kind;
    logic [1:0]  src;
    logic        inh;
    logic [3:0]  addr;
    logic [15:0] data;
  } pkt_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req, cpu_we, cpu_ack;
  logic [3:0] cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  pkt_t drv, obs;
  logic o_vld, o_inh;
  logic [2:0] o_kind;
  logic [1:0] o_src;
  logic [3:0] o_addr;
  logic [15:0] o_data;
  int n_vec = 0, n_bad = 0;
  logic [15:0] model [0:15];

  always #4 clk = ~clk;

  ring_dsm_node #(.NODE_ID(1), .NODE_W(2), .ENTRIES(4), .HOME_W(1),
                  .ADDR_W(4), .DATA_W(16), .LFSR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .ring_vld_i(drv.vld), .ring_kind_i(drv.kind), .ring_src_i(drv.src),
    .ring_inh_i(drv.inh), .ring_addr_i(drv.addr), .ring_data_i(drv.data),
    .ring_vld_o(o_vld), .ring_kind_o(o_kind), .ring_src_o(o_src),
    .ring_inh_o(o_inh), .ring_addr_o(o_addr), .ring_data_o(o_data));

  assign obs = {o_vld, o_kind, o_src, o_inh, o_addr, o_data};

  function automatic pkt_t mk(int k, int s, bit f, int a, int d);
    mk = '{vld: 1'b1, kind: 3'(k), src: 2'(s), inh: f, addr: 4'(a), data: 16'(d)};
  endfunction

  task automatic chk_pkt(input string rq, input pkt_t act, input pkt_t exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic chk_val(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  // one ring slot: drive at negedge, sample the registered output one edge later
  task automatic slot(input pkt_t p, output pkt_t o);
    drv = p;
    @(posedge clk);
    @(negedge clk);
    o = obs;
    drv = '0;
  endtask

  task automatic cpu_set(input bit we, input int a, input int d);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = 4'(a); cpu_wdata = 16'(d);
  endtask

  task automatic cpu_clr();
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic local_op(input bit we, input int a, input int d, input string rq);
    pkt_t o;
    cpu_set(we, a, d);
    slot('0, o);
    chk_val({rq, " ack"}, cpu_ack, 1);
    if (!we) chk_val({rq, " rdata"}, cpu_rdata, model[a]);
    chk_pkt({rq, " no ring traffic"}, o, '0);
    cpu_clr();
    if (we) model[a] = 16'(d);
    slot('0, o);
    chk_val("R13 ack pulse", cpu_ack, 0);
  endtask

  task automatic remote_op(input bit we, input int a, input int d, input int kind,
                           input int ret, input string rq);
    pkt_t o;
    cpu_set(we, a, d);
    slot('0, o);
    chk_pkt({rq, " waits for token"}, o, '0);
    slot(mk(K_TOK, 0, 0, 0, 0), o);
    chk_pkt({rq, " request packet"}, o, mk(kind, 1, 0, a, 0));
    slot(mk(kind, 1, 1, a, ret), o);
    chk_pkt({rq, " token released"}, o, mk(K_TOK, 1, 0, 0, 0));
    chk_val({rq, " ack"}, cpu_ack, 1);
    if (!we) chk_val({rq, " rdata"}, cpu_rdata, 16'(ret));
    cpu_clr();
    model[a] = we ? 16'(d) : 16'(ret);
    slot('0, o);
  endtask

  task automatic run_all();
    pkt_t o, p;
    int surv;
    // R1 reset state
    chk_val("R1 ack after reset", cpu_ack, 0);
    chk_pkt("R1 ring empty after reset", obs, '0);
    model[2] = 0; model[3] = 0;
    local_op(0, 2, 0, "R1 R2 home read 2");
    local_op(0, 3, 0, "R1 R2 home read 3");
    // R3 exclusive write
    local_op(1, 2, 16'hA5A5, "R3 excl write");
    local_op(0, 2, 0, "R3 read back");
    // R4 random foreign traffic on blocks not held
    for (int i = 0; i < 150; i++) begin
      int k, s;
      k = 1 + int'($urandom % 5);
      s = int'($urandom % 3); if (s == 1) s = 3;
      p = mk(k, s, 1'($urandom), 8 + int'($urandom % 8), int'($urandom % 65536));
      if ($urandom % 8 == 0) p = '0;
      slot(p, o);
      chk_pkt("R4 forward unchanged", o, p);
    end
    // R2/R3 random local traffic on home blocks
    for (int i = 0; i < 40; i++) begin
      int a;
      a = 2 + int'($urandom % 2);
      if ($urandom % 2 == 1) local_op(1, a, int'($urandom % 65536), "R3 random write");
      else                   local_op(0, a, 0, "R2 random read");
    end
    // R6 foreign read answered, then filled read ignored
    slot(mk(K_RD, 0, 0, 2, 0), o);
    chk_pkt("R6 read filled", o, mk(K_RD, 0, 1, 2, model[2]));
    slot(mk(K_RD, 3, 1, 2, 16'h1111), o);
    chk_pkt("R6 filled read passes", o, mk(K_RD, 3, 1, 2, 16'h1111));
    // R7 shared write needs invalidate, then exclusive
    remote_op(1, 2, 16'h7777, K_INV, 0, "R7 shared write");
    local_op(0, 2, 0, "R7 read after inval");
    local_op(1, 2, 16'h7778, "R7 now exclusive");
    // R5 read miss
    remote_op(0, 5, 0, K_RD, 16'h0505, "R5 read miss");
    local_op(0, 5, 0, "R5 read now hits");
    // R9 foreign invalidate drops copy
    slot(mk(K_INV, 3, 0, 5, 0), o);
    chk_pkt("R9 inval forwarded", o, mk(K_INV, 3, 0, 5, 0));
    remote_op(0, 5, 0, K_RD, 16'h0A0A, "R9 read misses after inval");
    slot(mk(K_RDI, 0, 0, 5, 0), o);
    chk_pkt("R9 rdinv filled", o, mk(K_RDI, 0, 1, 5, 16'h0A0A));
    // R8 write miss
    remote_op(1, 6, 16'h6666, K_RDI, 16'h1234, "R8 write miss");
    local_op(0, 6, 0, "R8 read back");
    local_op(1, 6, 16'h6667, "R8 exclusive");
    // R12 lost copy while invalidate pending
    remote_op(0, 4, 0, K_RD, 16'h0404, "R12 setup fill");
    cpu_set(1, 4, 16'h4444);
    slot('0, o);
    slot(mk(K_INV, 2, 0, 4, 0), o);
    chk_pkt("R12 foreign inval forwarded", o, mk(K_INV, 2, 0, 4, 0));
    slot(mk(K_TOK, 0, 0, 0, 0), o);
    chk_pkt("R12 inval sent", o, mk(K_INV, 1, 0, 4, 0));
    slot(mk(K_INV, 1, 0, 4, 0), o);
    chk_pkt("R12 token released", o, mk(K_TOK, 1, 0, 0, 0));
    chk_val("R12 no ack on lost copy", cpu_ack, 0);
    slot('0, o);
    slot(mk(K_TOK, 0, 0, 0, 0), o);
    chk_pkt("R12 retry as rdinv", o, mk(K_RDI, 1, 0, 4, 0));
    slot(mk(K_RDI, 1, 1, 4, 16'h0999), o);
    chk_val("R12 ack after retry", cpu_ack, 1);
    cpu_clr();
    model[4] = 16'h4444;
    slot('0, o);
    local_op(0, 4, 0, "R12 read back");
    // R10 eviction when full
    cpu_set(0, 7, 0);
    for (int k = 0; k < 40; k++) begin
      slot(mk(K_TOK, 0, 0, 0, 0), o);
      if (!(o.vld && o.kind == 3'(K_TOK))) break;
    end
    chk_val("R10 victim is a non-home cached block", 32'(o.addr == 4 || o.addr == 6), 1);
    chk_pkt("R10 evict packet", o, mk(K_EVC, 1, 0, o.addr, model[o.addr]));
    surv = (o.addr == 4) ? 6 : 4;
    slot(mk(K_EVC, 1, 1, o.addr, model[o.addr]), o);
    chk_pkt("R10 token after evict", o, mk(K_TOK, 1, 0, 0, 0));
    chk_val("R10 no ack on evict", cpu_ack, 0);
    for (int k = 0; k < 40; k++) begin
      slot(mk(K_TOK, 0, 0, 0, 0), o);
      if (!(o.vld && o.kind == 3'(K_TOK))) break;
    end
    chk_pkt("R10 read after evict", o, mk(K_RD, 1, 0, 7, 0));
    slot(mk(K_RD, 1, 1, 7, 16'h0707), o);
    chk_val("R10 ack", cpu_ack, 1);
    chk_val("R10 rdata", cpu_rdata, 16'h0707);
    cpu_clr();
    model[7] = 16'h0707;
    slot('0, o);
    local_op(0, surv, 0, "R10 survivor kept");
    local_op(0, 2, 0, "R10 home kept");
    local_op(0, 3, 0, "R10 home kept");
    // R11 evict returning home
    slot(mk(K_EVC, 2, 0, 3, 16'h3333), o);
    chk_pkt("R11 evict accepted", o, mk(K_EVC, 2, 1, 3, 16'h3333));
    model[3] = 16'h3333;
    local_op(0, 3, 0, "R11 home data");
    remote_op(1, 3, 16'h3334, K_INV, 0, "R11 home copy not exclusive");
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    drv = '0;
    cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule